// File: doc/BRIEF.md
# Serial Link Power-State Handshake Controller

This block is the link-layer state machine at one end of a serial storage link. It moves the link between an Active state and two low-power states, Partial and Slumber, using a request/acknowledge exchange of abstract primitive codes. The same RTL serves both ends of the link. A parameter chooses the host-side or device-side role, and that role decides who wins when both ends ask at the same moment.

A local policy block raises single-cycle request strobes. The controller then sends the matching request code and waits for the peer to accept or refuse it. When the peer is the one asking, the controller answers with one refusal, or with a burst of acceptances before it powers down. Once the link is in a low-power state it ignores primitives. It leaves only on an out-of-band wake, which it either sends itself or receives from the peer. When automatic partial-to-slumber is enabled, the controller can drop from Partial to Slumber without any exchange on the link.

Top module: `lpm_link_fsm`

## Requirements
- R1: After reset the link state is Active (0), the transmit code is none (0), the wake output is 0 and the PHY power-down output is 0.
- R2: In Active, a local partial strobe sends request-partial (code 1) and a local slumber strobe sends request-slumber (code 2), starting the cycle after the strobe. If both strobes arrive together, slumber wins. The request code holds while the controller waits for a reply.
- R3: An acknowledge (code 3) received while waiting moves the link in the next cycle to the requested state (Partial = 1, Slumber = 2) and asserts PHY power-down.
- R4: A negative-acknowledge (code 4) received while waiting returns the link to Active with no power-down and no transmit code.
- R5: With no reply, the request is held for exactly TIMEOUT cycles. The controller then drops it and stays Active.
- R6: In Active, a received request (code 1 or 2) is answered with ACK_COUNT consecutive acknowledges. The link then enters the requested state. Received codes 0 and 3 to 7 cause no action.
- R7: When reject_i is high, a received request is answered with a single negative-acknowledge and the link stays Active. With ALWAYS_ACK set, reject_i is ignored and no negative-acknowledge is ever sent.
- R8: In a low-power state the transmit code is none, and received primitives and the local partial strobe have no effect.
- R9: In Partial, the local slumber strobe moves the link to Slumber with no code sent, but only when aps_en_i is high. Otherwise the strobe is ignored.
- R10: In a low-power state, wake_i returns the link to Active in the next cycle and raises tx_wake_o for exactly one cycle. rx_wake_i returns the link to Active without raising tx_wake_o.
- R11: On the host side (IS_HOST=1), a local request beats a request received in the same cycle, and requests received while waiting are ignored. On the device side, a received request beats its own local request, both in Active and while waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_partial_i | input | 1 | Local strobe asking for Partial |
| req_slumber_i | input | 1 | Local strobe asking for Slumber |
| wake_i | input | 1 | Local request to leave a low-power state |
| reject_i | input | 1 | Refuse received requests (ignored when ALWAYS_ACK) |
| aps_en_i | input | 1 | Automatic partial-to-slumber enabled on both ends |
| rx_prim_i | input | 3 | Received primitive code |
| rx_wake_i | input | 1 | Out-of-band wake detected from peer |
| tx_prim_o | output | 3 | Primitive code to transmit |
| tx_wake_o | output | 1 | One-cycle out-of-band wake request |
| link_state_o | output | 2 | 0 Active, 1 Partial, 2 Slumber |
| phy_pd_o | output | 1 | PHY power-down enable |

## Verification
The bench sweeps the reply delay across the whole timeout window for both request kinds and each reply type. A controller with an off-by-one wait counter would drop a late acknowledge or keep requesting one cycle too long. Every received code 0 to 7 is applied in Active, with and without a refusal. This catches a wrong acknowledge-burst length, spurious reactions to undefined codes, and a device that refuses anyway. Same-cycle and mid-wait collisions are driven on both roles: a wrong priority shows up as an acknowledge from the host, or a request left standing on the device. Stimulus applied in low-power states catches a controller that reacts to primitives or skips through Partial to Slumber without the automatic mode.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    PRIM_NONE  = 3'd0,
    PRIM_REQ_P = 3'd1,
    PRIM_REQ_S = 3'd2,
    PRIM_ACK   = 3'd3,
    PRIM_NAK   = 3'd4
  } prim_e;

  typedef enum logic [1:0] {
    LINK_ACTIVE  = 2'd0,
    LINK_PARTIAL = 2'd1,
    LINK_SLUMBER = 2'd2
  } link_e;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_WAIT,
    ST_ACK,
    ST_NAK,
    ST_PARTIAL,
    ST_SLUMBER
  } fsm_e;
endpackage

// File: rtl/lpm_counter.sv
module lpm_counter #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/lpm_rx_decode.sv
module lpm_rx_decode
  import lpm_pkg::*;
(
  input  logic [2:0] code_i,
  output logic       is_req_o,
  output logic       req_slm_o,
  output logic       is_ack_o,
  output logic       is_nak_o
);
  always_comb begin
    is_req_o  = (code_i == PRIM_REQ_P) || (code_i == PRIM_REQ_S);
    req_slm_o = (code_i == PRIM_REQ_S);
    is_ack_o  = (code_i == PRIM_ACK);
    is_nak_o  = (code_i == PRIM_NAK);
  end
endmodule

// File: rtl/lpm_link_fsm.sv
module lpm_link_fsm
  import lpm_pkg::*;
#(
  parameter bit IS_HOST    = 1'b1,
  parameter bit ALWAYS_ACK = 1'b0,
  parameter int ACK_COUNT  = 4,
  parameter int TIMEOUT    = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_partial_i,
  input  logic       req_slumber_i,
  input  logic       wake_i,
  input  logic       reject_i,
  input  logic       aps_en_i,
  input  logic [2:0] rx_prim_i,
  input  logic       rx_wake_i,
  output logic [2:0] tx_prim_o,
  output logic       tx_wake_o,
  output logic [1:0] link_state_o,
  output logic       phy_pd_o
);
  localparam int MAXC = (TIMEOUT > ACK_COUNT) ? TIMEOUT : ACK_COUNT;
  localparam int CW   = $clog2(MAXC + 1);

  fsm_e        st_q, st_d;
  logic        tgt_slm_q, tgt_slm_d;
  logic        wake_d;
  logic        rx_req, rx_slm, rx_ack, rx_nak;
  logic        cnt_clr, cnt_en;
  logic [CW-1:0] cnt;
  logic        accept;
  logic        local_req;

  lpm_rx_decode u_dec (
    .code_i   (rx_prim_i),
    .is_req_o (rx_req),
    .req_slm_o(rx_slm),
    .is_ack_o (rx_ack),
    .is_nak_o (rx_nak)
  );

  lpm_counter #(.W(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  assign accept    = ALWAYS_ACK ? 1'b1 : !reject_i;
  assign local_req = req_partial_i || req_slumber_i;
  assign cnt_en    = (st_q == ST_WAIT) || (st_q == ST_ACK);
  assign cnt_clr   = (st_d != st_q);

  always_comb begin
    st_d      = st_q;
    tgt_slm_d = tgt_slm_q;
    wake_d    = 1'b0;
    unique case (st_q)
      ST_ACTIVE: begin
        if (rx_req && (!IS_HOST || !local_req)) begin
          tgt_slm_d = rx_slm;
          st_d      = accept ? ST_ACK : ST_NAK;
        end else if (local_req) begin
          tgt_slm_d = req_slumber_i;
          st_d      = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rx_ack)                   st_d = tgt_slm_q ? ST_SLUMBER : ST_PARTIAL;
        else if (rx_nak)              st_d = ST_ACTIVE;
        else if (rx_req && !IS_HOST) begin
          tgt_slm_d = rx_slm;
          st_d      = accept ? ST_ACK : ST_NAK;
        end
        else if (cnt == CW'(TIMEOUT - 1)) st_d = ST_ACTIVE;
      end
      ST_ACK: if (cnt == CW'(ACK_COUNT - 1)) st_d = tgt_slm_q ? ST_SLUMBER : ST_PARTIAL;
      ST_NAK: st_d = ST_ACTIVE;
      ST_PARTIAL, ST_SLUMBER: begin
        if (wake_i) begin
          st_d   = ST_ACTIVE;
          wake_d = 1'b1;
        end else if (rx_wake_i) begin
          st_d = ST_ACTIVE;
        end else if (st_q == ST_PARTIAL && aps_en_i && req_slumber_i) begin
          st_d = ST_SLUMBER;  // implicit move, nothing sent
        end
      end
      default: st_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_ACTIVE;
      tgt_slm_q <= 1'b0;
      tx_wake_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      tgt_slm_q <= tgt_slm_d;
      tx_wake_o <= wake_d;
    end
  end

  always_comb begin
    tx_prim_o    = PRIM_NONE;
    link_state_o = LINK_ACTIVE;
    phy_pd_o     = 1'b0;
    case (st_q)
      ST_WAIT:    tx_prim_o = tgt_slm_q ? PRIM_REQ_S : PRIM_REQ_P;
      ST_ACK:     tx_prim_o = PRIM_ACK;
      ST_NAK:     tx_prim_o = PRIM_NAK;
      ST_PARTIAL: begin link_state_o = LINK_PARTIAL; phy_pd_o = 1'b1; end
      ST_SLUMBER: begin link_state_o = LINK_SLUMBER; phy_pd_o = 1'b1; end
      default: ;
    endcase
  end

  assert_pd_after_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_pd_o) |-> ($past(tx_prim_o) == PRIM_ACK) || $past(rx_ack));

  assert_nak_stays_active_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) && rx_nak |=> !phy_pd_o && (link_state_o == LINK_ACTIVE));

  assert_quiet_low_power_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_pd_o |-> (tx_prim_o == PRIM_NONE));

  assert_no_direct_p2s_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_state_o == LINK_PARTIAL) && !aps_en_i |=> (link_state_o != LINK_SLUMBER));

  assert_wake_to_active_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_pd_o && (wake_i || rx_wake_i) |=> (link_state_o == LINK_ACTIVE) && !phy_pd_o);

  generate
    if (ALWAYS_ACK) begin : g_never_nak
      assert_never_nak_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_prim_o != PRIM_NAK);
    end
    if (IS_HOST) begin : g_host_wins
      assert_host_keeps_request_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_WAIT) && rx_req && !rx_ack |=> (tx_prim_o != PRIM_ACK));
    end
  endgenerate
endmodule

// File: tb/lpm_link_fsm_bench.sv
module lpm_link_fsm_bench;
  localparam int ACKN = 3;
  localparam int TMO  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic h_rp = 0, h_rs = 0, h_wk = 0, h_rej = 0, h_aps = 0, h_rwk = 0;
  logic [2:0] h_rx = 0;
  logic [2:0] h_tx; logic h_txw; logic [1:0] h_ls; logic h_pd;
  logic d_rp = 0, d_rs = 0, d_wk = 0, d_rej = 0, d_aps = 0, d_rwk = 0;
  logic [2:0] d_rx = 0;
  logic [2:0] d_tx; logic d_txw; logic [1:0] d_ls; logic d_pd;

  lpm_link_fsm #(.IS_HOST(1'b1), .ALWAYS_ACK(1'b0), .ACK_COUNT(ACKN), .TIMEOUT(TMO)) u_lpm_link_fsm (
    .clk_i(clk), .rst_ni(rst_n), .req_partial_i(h_rp), .req_slumber_i(h_rs), .wake_i(h_wk),
    .reject_i(h_rej), .aps_en_i(h_aps), .rx_prim_i(h_rx), .rx_wake_i(h_rwk),
    .tx_prim_o(h_tx), .tx_wake_o(h_txw), .link_state_o(h_ls), .phy_pd_o(h_pd));

  lpm_link_fsm #(.IS_HOST(1'b0), .ALWAYS_ACK(1'b1), .ACK_COUNT(ACKN), .TIMEOUT(TMO)) u_lpm_link_fsm_dev (
    .clk_i(clk), .rst_ni(rst_n), .req_partial_i(d_rp), .req_slumber_i(d_rs), .wake_i(d_wk),
    .reject_i(d_rej), .aps_en_i(d_aps), .rx_prim_i(d_rx), .rx_wake_i(d_rwk),
    .tx_prim_o(d_tx), .tx_wake_o(d_txw), .link_state_o(d_ls), .phy_pd_o(d_pd));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  // host request, reply kind 0 none, 1 ack, 2 nak, after d idle cycles
  task automatic host_req(input bit slm, input int kind, input int d);
    h_rp = !slm; h_rs = slm; tick(); h_rp = 0; h_rs = 0;
    chk("R2 request code", h_tx, slm ? 2 : 1);
    if (kind == 0) begin
      repeat (TMO - 1) tick();
      chk("R5 still requesting", h_tx, slm ? 2 : 1);
      tick();
      chk("R5 timeout tx", h_tx, 0);
      chk("R5 timeout state", h_ls, 0);
    end else begin
      repeat (d) tick();
      chk("R2 request held", h_tx, slm ? 2 : 1);
      h_rx = (kind == 1) ? 3'd3 : 3'd4; tick(); h_rx = 0;
      if (kind == 1) begin
        chk("R3 state", h_ls, slm ? 2 : 1);
        chk("R3 pd", h_pd, 1);
        h_wk = 1; tick(); h_wk = 0;
        chk("R10 state after wake", h_ls, 0);
        chk("R10 wake pulse", h_txw, 1);
        tick();
        chk("R10 wake pulse width", h_txw, 0);
      end else begin
        chk("R4 state", h_ls, 0);
        chk("R4 pd", h_pd, 0);
        chk("R4 tx", h_tx, 0);
      end
    end
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 state", h_ls, 0); chk("R1 tx", h_tx, 0);
    chk("R1 pd", h_pd, 0);    chk("R1 wake", h_txw, 0);
    rst_n = 1; tick();

    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < TMO; d++) begin
        host_req(s[0], 1, d);
        host_req(s[0], 2, d);
      end
      host_req(s[0], 0, 0);
    end

    // R2 both strobes: slumber wins
    h_rp = 1; h_rs = 1; tick(); h_rp = 0; h_rs = 0;
    chk("R2 both strobes", h_tx, 2);
    h_rx = 3'd4; tick(); h_rx = 0;

    // R6/R7 device sweep, reject ignored by ALWAYS_ACK
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < 8; c++) begin
        d_rej = r[0]; d_rx = c[2:0]; tick(); d_rx = 0; d_rej = 0;
        if (c == 1 || c == 2) begin
          for (int k = 0; k < ACKN; k++) begin
            chk("R6 ack burst", d_tx, 3);
            chk("R6 active during burst", d_ls, 0);
            tick();
          end
          chk("R6 entered state", d_ls, c);
          chk("R6 pd", d_pd, 1);
          d_rwk = 1; tick(); d_rwk = 0;
          chk("R10 rx wake state", d_ls, 0);
          chk("R10 no tx wake", d_txw, 0);
        end else begin
          chk("R6 ignored code tx", d_tx, 0);
          chk("R6 ignored code state", d_ls, 0);
        end
      end
    end

    // R7 host refuses
    h_rej = 1; h_rx = 3'd2; tick(); h_rx = 0; h_rej = 0;
    chk("R7 nak sent", h_tx, 4);
    tick();
    chk("R7 nak single tx", h_tx, 0);
    chk("R7 stays active", h_ls, 0);

    // R8/R9 device in Partial
    d_rx = 3'd1; tick(); d_rx = 0; repeat (ACKN) tick();
    chk("R8 in partial", d_ls, 1);
    for (int c = 1; c < 5; c++) begin
      d_rx = c[2:0]; tick(); d_rx = 0;
      chk("R8 rx ignored state", d_ls, 1);
      chk("R8 rx ignored tx", d_tx, 0);
    end
    d_rp = 1; tick(); d_rp = 0;
    chk("R8 local partial ignored", d_ls, 1);
    d_rs = 1; tick(); d_rs = 0;
    chk("R9 slumber without aps ignored", d_ls, 1);
    chk("R9 no request sent", d_tx, 0);
    d_aps = 1; d_rs = 1; tick(); d_rs = 0; d_aps = 0;
    chk("R9 implicit slumber", d_ls, 2);
    chk("R9 nothing sent", d_tx, 0);
    d_wk = 1; tick(); d_wk = 0;
    chk("R10 device wake", d_ls, 0);
    chk("R10 device wake pulse", d_txw, 1);

    // R11 host collision
    h_rp = 1; h_rx = 3'd2; tick(); h_rp = 0; h_rx = 0;
    chk("R11 host own request wins", h_tx, 1);
    h_rx = 3'd2; tick(); h_rx = 0;
    chk("R11 host ignores rx request", h_tx, 1);
    h_rx = 3'd3; tick(); h_rx = 0;
    chk("R11 host completes own", h_ls, 1);
    h_rwk = 1; tick(); h_rwk = 0;
    chk("R10 host rx wake", h_ls, 0);
    chk("R10 host rx wake no pulse", h_txw, 0);

    // R11 device collision, same cycle and while waiting
    d_rp = 1; d_rx = 3'd2; tick(); d_rp = 0; d_rx = 0;
    chk("R11 device answers", d_tx, 3);
    repeat (ACKN) tick();
    chk("R11 device follows host", d_ls, 2);
    d_rwk = 1; tick(); d_rwk = 0;
    d_rp = 1; tick(); d_rp = 0;
    chk("R11 device waiting", d_tx, 1);
    d_rx = 3'd2; tick(); d_rx = 0;
    chk("R11 device yields while waiting", d_tx, 3);
    repeat (ACKN) tick();
    chk("R11 device in slumber", d_ls, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule